// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block orders the two power-related outputs of an LCD panel: the enable for the panel bias supply and the gate for the panel data and timing signals. Software controls it through a panel-enable level and a manual bias-off level. A once-per-frame vertical non-display pulse supplies the time base.

Power-down always removes bias first. The block then waits a fixed number of frames so the bias supply can discharge, and only after that gates off the signals. Power-up runs in the reverse order: the signals come on first, and bias follows at the next frame boundary.

The manual bias-off level forces bias off at any time while the signals stay active. Software can therefore stretch the discharge time: it holds bias off, counts its own frames, and then clears panel-enable. A busy output and a two-bit state output let software poll the sequence.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After reset, bias_en_o, sig_en_o and busy_o are 0 and state_o is 0 (idle).
- R2: The state_o encoding is 0 idle, 1 powering up, 2 on, 3 discharging.
- R3: When panel_en_i is sampled at 1 in idle, sig_en_o goes to 1 after that clock edge, while bias_en_o stays 0 and state_o becomes 1.
- R4: In the powering-up state, bias_en_o goes to 1 after the first clock edge at which vnd_i is 1 and was 0 on the previous edge (a frame boundary), provided bias_off_i is 0. A level held at 1 counts as only one boundary.
- R5: While bias_off_i is 1, bias_en_o is 0 in the same cycle in every state, and the powering-up state does not advance across frame boundaries. In the on state, returning bias_off_i to 0 restores bias_en_o in the same cycle.
- R6: When panel_en_i is sampled at 0 in the on state, bias_en_o drops after that edge, sig_en_o stays 1, busy_o rises and state_o becomes 3.
- R7: Discharge ends on the 128th frame boundary after entry. After 127 boundaries sig_en_o is still 1, and after the 128th it is 0 with state_o at 0.
- R8: busy_o is 1 exactly while the state is discharging.
- R9: If panel_en_i is sampled at 1 during discharge, the wait is aborted. busy_o drops, sig_en_o stays 1, state_o becomes 1 and bias returns under R4. A later power-down counts the full 128 frames again.
- R10: When panel_en_i is sampled at 0 in the powering-up state, sig_en_o drops after that edge and state_o returns to 0 with no discharge wait.
- R11: bias_en_o is never 1 while sig_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| panel_en_i | input | 1 | Software panel-enable level |
| bias_off_i | input | 1 | Software manual bias-off override |
| vnd_i | input | 1 | Vertical non-display indication, one pulse per frame |
| bias_en_o | output | 1 | Panel bias supply enable |
| sig_en_o | output | 1 | Panel data/timing signal gate |
| busy_o | output | 1 | High during the discharge wait |
| state_o | output | 2 | Sequencer state (encoding in R2) |

## Verification
The hardest case to reach is an abort part-way through a discharge, followed by a second power-down. Showing that the counter really restarted requires proof that the signals survive a full 127 further frames. The stimulus therefore powers down, feeds 50 frame pulses, and re-asserts panel-enable. It then lets bias return on one frame edge, powers down again, and checks the signal gate at frame 127 and at frame 128. The software-stretched delay is reached in a similar way: bias-off is held through several frames in the on state, and panel-enable is cleared only afterwards.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_UPWAIT = 2'd1,
    ST_ON     = 2'd2,
    ST_DISCH  = 2'd3
  } lps_state_e;
endpackage

// File: rtl/lps_rst_sync.sv
module lps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/lps_edge_det.sv
module lps_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/lps_frame_cnt.sv
module lps_frame_cnt #(
  parameter int CNT_W  = 8,
  parameter int FRAMES = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAMES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = 1'b0;
    cnt_d  = cnt_q;
    if (!run_i) begin
      cnt_ce = (cnt_q != '0);
      cnt_d  = '0;
    end else if (tick_i) begin
      cnt_ce = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign done_o = run_i & tick_i & (cnt_q == LAST);
endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
  import lps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       panel_en_i,
  input  logic       bias_off_i,
  input  logic       tick_i,
  input  logic       done_i,
  output logic       run_o,
  output logic       bias_en_o,
  output logic       sig_en_o,
  output logic       busy_o,
  output logic [1:0] state_o
);
  lps_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (panel_en_i) state_d = ST_UPWAIT;
      ST_UPWAIT: begin
        if (!panel_en_i)                state_d = ST_IDLE;
        else if (tick_i && !bias_off_i) state_d = ST_ON;
      end
      ST_ON:     if (!panel_en_i) state_d = ST_DISCH;
      ST_DISCH: begin
        if (panel_en_i)  state_d = ST_UPWAIT;
        else if (done_i) state_d = ST_IDLE;
      end
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign run_o     = (state_q == ST_DISCH);
  assign busy_o    = (state_q == ST_DISCH);
  assign sig_en_o  = (state_q != ST_IDLE);
  assign bias_en_o = (state_q == ST_ON) & ~bias_off_i;
  assign state_o   = state_q;
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq #(
  parameter int DISCHARGE_FRAMES = 128,
  parameter int RST_STAGES       = 2,
  localparam int CNT_W           = $clog2(DISCHARGE_FRAMES) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       panel_en_i,
  input  logic       bias_off_i,
  input  logic       vnd_i,
  output logic       bias_en_o,
  output logic       sig_en_o,
  output logic       busy_o,
  output logic [1:0] state_o
);
  logic rst_n_int;
  logic frame_tick;
  logic cnt_run;
  logic cnt_done;

  lps_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  lps_edge_det u_edge (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .level_i (vnd_i),
    .rise_o  (frame_tick)
  );

  lps_frame_cnt #(.CNT_W(CNT_W), .FRAMES(DISCHARGE_FRAMES)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .run_i  (cnt_run),
    .tick_i (frame_tick),
    .done_o (cnt_done)
  );

  lps_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .panel_en_i (panel_en_i),
    .bias_off_i (bias_off_i),
    .tick_i     (frame_tick),
    .done_i     (cnt_done),
    .run_o      (cnt_run),
    .bias_en_o  (bias_en_o),
    .sig_en_o   (sig_en_o),
    .busy_o     (busy_o),
    .state_o    (state_o)
  );
endmodule

// File: rtl/lcd_pwr_seq_chk.sv
module lcd_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       panel_en_i,
  input logic       bias_off_i,
  input logic       vnd_i,
  input logic       bias_en_o,
  input logic       sig_en_o,
  input logic       busy_o,
  input logic [1:0] state_o
);
  a_r11_bias_needs_sig: assert property (@(posedge clk) disable iff (!rst_n)
    bias_en_o |-> sig_en_o);

  a_r5_override_kills_bias: assert property (@(posedge clk) disable iff (!rst_n)
    bias_off_i |-> !bias_en_o);

  a_r5_upwait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_off_i && panel_en_i && state_o == 2'd1) |=> state_o == 2'd1);

  a_r6_busy_rise_from_on: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(state_o) == 2'd2 && !$past(panel_en_i)));

  a_r6_no_bias_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!bias_en_o && sig_en_o));

  a_r4_bias_up_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bias_en_o) && $past(state_o) == 2'd1) |-> $past(vnd_i));

  a_r7_sig_drop_source: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sig_en_o) |-> ($past(state_o) == 2'd3 || $past(state_o) == 2'd1));
endmodule

bind lcd_pwr_seq lcd_pwr_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .panel_en_i (panel_en_i),
  .bias_off_i (bias_off_i),
  .vnd_i      (vnd_i),
  .bias_en_o  (bias_en_o),
  .sig_en_o   (sig_en_o),
  .busy_o     (busy_o),
  .state_o    (state_o)
);

// File: tb/sim_lcd_pwr_seq.sv
module sim_lcd_pwr_seq;
  logic       clk;
  logic       rst_n;
  logic       panel_en_i;
  logic       bias_off_i;
  logic       vnd_i;
  logic       bias_en_o;
  logic       sig_en_o;
  logic       busy_o;
  logic [1:0] state_o;

  int checks;
  int failures;

  lcd_pwr_seq u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .panel_en_i (panel_en_i),
    .bias_off_i (bias_off_i),
    .vnd_i      (vnd_i),
    .bias_en_o  (bias_en_o),
    .sig_en_o   (sig_en_o),
    .busy_o     (busy_o),
    .state_o    (state_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic b, input logic s,
                     input logic bz, input logic [1:0] st);
    checks++;
    if (bias_en_o !== b || sig_en_o !== s || busy_o !== bz || state_o !== st) begin
      failures++;
      $display("FAIL %s: got bias=%b sig=%b busy=%b state=%0d, expected bias=%b sig=%b busy=%b state=%0d",
               req, bias_en_o, sig_en_o, busy_o, state_o, b, s, bz, st);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      vnd_i = 1'b1;
      step();
      vnd_i = 1'b0;
      step();
    end
  endtask

  task automatic t_reset();
    chk("R1 reset state", 1'b0, 1'b0, 1'b0, 2'd0);
  endtask

  task automatic t_powerup();
    panel_en_i = 1'b1;
    step();
    chk("R3 signals first, R2 state 1", 1'b0, 1'b1, 1'b0, 2'd1);
    vnd_i = 1'b1;
    step();
    chk("R4 bias on first frame edge", 1'b1, 1'b1, 1'b0, 2'd2);
    vnd_i = 1'b0;
    step();
  endtask

  task automatic t_override_on();
    bias_off_i = 1'b1;
    #1;
    chk("R5 override forces bias off", 1'b0, 1'b1, 1'b0, 2'd2);
    bias_off_i = 1'b0;
    #1;
    chk("R5 override release restores bias", 1'b1, 1'b1, 1'b0, 2'd2);
  endtask

  task automatic t_discharge();
    panel_en_i = 1'b0;
    step();
    chk("R6 bias off first, R8 busy", 1'b0, 1'b1, 1'b1, 2'd3);
    frames(127);
    chk("R7 signals still on after 127 frames", 1'b0, 1'b1, 1'b1, 2'd3);
    frames(1);
    chk("R7 signals off after 128 frames, R8 busy low", 1'b0, 1'b0, 1'b0, 2'd0);
  endtask

  task automatic t_abort();
    t_powerup();
    panel_en_i = 1'b0;
    step();
    frames(50);
    panel_en_i = 1'b1;
    step();
    chk("R9 abort keeps signals, busy low", 1'b0, 1'b1, 1'b0, 2'd1);
    frames(1);
    chk("R9 bias back on next frame", 1'b1, 1'b1, 1'b0, 2'd2);
    panel_en_i = 1'b0;
    step();
    frames(127);
    chk("R9 counter restarted after abort", 1'b0, 1'b1, 1'b1, 2'd3);
    frames(1);
    chk("R9 second power-down completes", 1'b0, 1'b0, 1'b0, 2'd0);
  endtask

  task automatic t_level_not_edge();
    vnd_i = 1'b1;
    step();
    panel_en_i = 1'b1;
    step();
    step();
    step();
    chk("R4 held level is not a new frame", 1'b0, 1'b1, 1'b0, 2'd1);
    vnd_i = 1'b0;
    step();
    panel_en_i = 1'b0;
    step();
    chk("R10 cancel during power-up", 1'b0, 1'b0, 1'b0, 2'd0);
  endtask

  task automatic t_manual_long();
    bias_off_i = 1'b1;
    panel_en_i = 1'b1;
    step();
    frames(3);
    chk("R5 power-up held while override set", 1'b0, 1'b1, 1'b0, 2'd1);
    bias_off_i = 1'b0;
    frames(1);
    chk("R4 bias on after override released", 1'b1, 1'b1, 1'b0, 2'd2);
    bias_off_i = 1'b1;
    frames(10);
    chk("R5 software delay keeps signals active", 1'b0, 1'b1, 1'b0, 2'd2);
    panel_en_i = 1'b0;
    step();
    chk("R6 discharge after software delay", 1'b0, 1'b1, 1'b1, 2'd3);
    frames(128);
    chk("R7 off after software delay", 1'b0, 1'b0, 1'b0, 2'd0);
    bias_off_i = 1'b0;
    step();
    chk("R11 idle stays dark", 1'b0, 1'b0, 1'b0, 2'd0);
  endtask

  initial begin
    checks     = 0;
    failures   = 0;
    rst_n      = 1'b0;
    panel_en_i = 1'b0;
    bias_off_i = 1'b0;
    vnd_i      = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_powerup();
    t_override_on();
    t_discharge();
    t_abort();
    t_level_not_edge();
    t_manual_long();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    failures++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule